// File: doc/BRIEF.md
# Bidirectional GPIO Port with Peripheral Override

This block is an 8-bit general-purpose I/O port that sits on a simple microcontroller-style register bus. Each pin owns a direction bit, an output data latch bit and a synchronised input path. Software writes the latch through either of two write strobes and the direction register through a third. It reads back the latch, the direction register or the synchronised pin level through three separate read strobes. Because the latch and the pin level have their own read paths, read-modify-write on the latch never picks up a pin that some external source is pulling.

Each pin also has a peripheral enable, an output select and a data-out signal. When an on-chip peripheral is enabled on a pin that is able to take an override, it decides the pin direction without touching the stored direction bit. When the peripheral selects output, the pin drives the peripheral's data instead of the latch. The synchronised pin level goes back to the peripherals as well. The pad is modelled as three separate signals: drive value, drive enable and input level.

All bus signals are plain single-cycle strobes. The port is always ready, so there is no back-pressure: a write is taken on the rising edge at which its strobe is high, and read data is combinational from current state in the same cycle as the read strobe.

Top module: `gpio_ovr_port`

## Requirements
- R1: After reset, every direction bit reads 1, every latch bit reads 0, `pad_oe` is 0x00 and the port readback is 0x00.
- R2: With no peripheral enabled on a pin, a direction bit of 1 turns the driver off (`pad_oe`=0). A direction bit of 0 turns it on (`pad_oe`=1) and `pad_out` carries the latch bit.
- R3: A write strobe on `wr_lat` or on `wr_port` loads `wdata` into the latch on that rising edge. `rd_lat` returns the latch, not the pin level.
- R4: `wr_dir` loads `wdata` into the direction register on that rising edge. `rd_dir` returns the stored value.
- R5: A change on `pad_in` appears on the port readback and on `periph_din` after exactly two rising edges, and not after one.
- R6: Read data priority is `rd_port` over `rd_lat` over `rd_dir`. With no read strobe, `rdata` is 0x00.
- R7: On an override-capable pin with its peripheral enabled, output select 1 forces the pin to output and output select 0 forces it to input, whatever its direction bit holds.
- R8: On any pin with its peripheral enabled and output select 1, `pad_out` carries `periph_dout` instead of the latch.
- R9: An override never changes the direction register. `rd_dir` returns the value last written while overrides are active and after they are released.
- R10: The override-capable mask is a parameter whose default covers pins 0 to 6. Pin 7's drive enable follows its direction bit even when its peripheral is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wdata | input | 8 | Bus write data |
| wr_lat | input | 1 | Write strobe for the output latch |
| wr_port | input | 1 | Write strobe for the port register (also loads the latch) |
| wr_dir | input | 1 | Write strobe for the direction register |
| rd_port | input | 1 | Read strobe for the synchronised pin level |
| rd_lat | input | 1 | Read strobe for the output latch |
| rd_dir | input | 1 | Read strobe for the direction register |
| rdata | output | 8 | Bus read data |
| periph_en | input | 8 | Per-pin peripheral enable |
| periph_osel | input | 8 | Per-pin peripheral output select |
| periph_dout | input | 8 | Per-pin peripheral drive data |
| periph_din | output | 8 | Synchronised pin level returned to peripherals |
| pad_in | input | 8 | Pad input level |
| pad_out | output | 8 | Pad drive value |
| pad_oe | output | 8 | Pad drive enable, 1 = driving |

## Verification
Several behaviours are checked by the assertions on every cycle: register writes landing on the next edge, the direction register holding steady with no write strobe even under overrides, the two-edge synchroniser latency, and forced direction and data whenever an override is active. The bench scenarios are needed for the things that depend on what software sees. These are the read priority among the strobes, the reset values seen through the bus, the latch readback differing from a pin that is pulled elsewhere, and pin 7 ignoring a direction override.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  localparam int unsigned PORT_W = 8;

  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_PIN  = 2'd1,
    RSEL_LAT  = 2'd2,
    RSEL_DIR  = 2'd3
  } rsel_e;

  function automatic rsel_e pick_read(input logic pin, input logic lat, input logic dir);
    if (pin)      return RSEL_PIN;
    else if (lat) return RSEL_LAT;
    else if (dir) return RSEL_DIR;
    else          return RSEL_NONE;
  endfunction
endpackage

// File: rtl/gpio_ovr_regs.sv
module gpio_ovr_regs #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] wdata,
  input  logic         wr_lat,
  input  logic         wr_port,
  input  logic         wr_dir,
  output logic [W-1:0] lat_q,
  output logic [W-1:0] dir_q
);
  logic lat_we;
  assign lat_we = wr_lat | wr_port;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      dir_q <= '1;
    end else begin
      if (lat_we) lat_q <= wdata;
      if (wr_dir) dir_q <= wdata;
    end
  end

  p_lat_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lat || wr_port) |=> (lat_q == $past(wdata)));

  p_dir_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (dir_q == $past(wdata)));

  // R9: only a bus write may move the direction register, overrides never do
  p_dir_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(dir_q));
endmodule

// File: rtl/gpio_ovr_sync.sv
module gpio_ovr_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else if (s == 0) stg[s] <= d;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stg[STAGES-1];

  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  if (STAGES == 2) begin : g_lat_chk
    p_sync_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 2'd2) |-> (q == $past(d, 2)));
  end
endmodule

// File: rtl/gpio_ovr_pinmux.sv
module gpio_ovr_pinmux #(
  parameter int unsigned   W        = 8,
  parameter logic [W-1:0]  OVR_MASK = {1'b0, {(W-1){1'b1}}}
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lat_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] periph_en,
  input  logic [W-1:0] periph_osel,
  input  logic [W-1:0] periph_dout,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic take_data;
    assign take_data = periph_en[i] & periph_osel[i];
    assign pad_out[i] = take_data ? periph_dout[i] : lat_q[i];

    if (OVR_MASK[i]) begin : g_ovr
      assign pad_oe[i] = periph_en[i] ? periph_osel[i] : ~dir_q[i];

      p_force_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_en[i] && periph_osel[i]) |-> (pad_oe[i] && pad_out[i] == periph_dout[i]));
      p_force_in_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (periph_en[i] && !periph_osel[i]) |-> !pad_oe[i]);
    end else begin : g_fixed
      assign pad_oe[i] = ~dir_q[i];

      p_no_ovr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        periph_en[i] |-> (pad_oe[i] != dir_q[i]));
    end
  end
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
  import gpio_ovr_pkg::*;
#(
  parameter int unsigned        W           = PORT_W,
  parameter logic [W-1:0]       OVR_MASK    = {1'b0, {(W-1){1'b1}}},
  parameter int unsigned        SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] wdata,
  input  logic         wr_lat,
  input  logic         wr_port,
  input  logic         wr_dir,
  input  logic         rd_port,
  input  logic         rd_lat,
  input  logic         rd_dir,
  output logic [W-1:0] rdata,
  input  logic [W-1:0] periph_en,
  input  logic [W-1:0] periph_osel,
  input  logic [W-1:0] periph_dout,
  output logic [W-1:0] periph_din,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  logic [W-1:0] lat_q, dir_q, pin_s;
  rsel_e        rsel;

  gpio_ovr_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wdata(wdata),
    .wr_lat(wr_lat), .wr_port(wr_port), .wr_dir(wr_dir),
    .lat_q(lat_q), .dir_q(dir_q)
  );

  gpio_ovr_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_s)
  );

  gpio_ovr_pinmux #(.W(W), .OVR_MASK(OVR_MASK)) u_mux (
    .clk(clk), .rst_n(rst_n), .lat_q(lat_q), .dir_q(dir_q),
    .periph_en(periph_en), .periph_osel(periph_osel), .periph_dout(periph_dout),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  assign periph_din = pin_s;
  assign rsel = pick_read(rd_port, rd_lat, rd_dir);

  always_comb begin
    unique case (rsel)
      RSEL_PIN: rdata = pin_s;
      RSEL_LAT: rdata = lat_q;
      RSEL_DIR: rdata = dir_q;
      default:  rdata = '0;
    endcase
  end

  p_idle_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_port && !rd_lat && !rd_dir) |-> (rdata == '0));

  p_pin_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_port |-> (rdata == periph_din));
endmodule

// File: tb/gpio_ovr_port_test.sv
module gpio_ovr_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] wdata = '0;
  logic       wr_lat = 0, wr_port = 0, wr_dir = 0;
  logic       rd_port = 0, rd_lat = 0, rd_dir = 0;
  logic [7:0] rdata;
  logic [7:0] periph_en = '0, periph_osel = '0, periph_dout = '0;
  logic [7:0] periph_din;
  logic [7:0] pad_in = '0;
  logic [7:0] pad_out, pad_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_ovr_port uut (
    .clk(clk), .rst_n(rst_n), .wdata(wdata),
    .wr_lat(wr_lat), .wr_port(wr_port), .wr_dir(wr_dir),
    .rd_port(rd_port), .rd_lat(rd_lat), .rd_dir(rd_dir), .rdata(rdata),
    .periph_en(periph_en), .periph_osel(periph_osel), .periph_dout(periph_dout),
    .periph_din(periph_din), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_write(input int which, input logic [7:0] v);
    @(negedge clk);
    wdata = v;
    wr_lat = (which == 0); wr_port = (which == 1); wr_dir = (which == 2);
    @(negedge clk);
    wr_lat = 0; wr_port = 0; wr_dir = 0;
  endtask

  // 0 = port, 1 = latch, 2 = direction; sampled at a negative edge
  task automatic do_read(input int which, output logic [7:0] v);
    rd_port = (which == 0); rd_lat = (which == 1); rd_dir = (which == 2);
    #1 v = rdata;
    rd_port = 0; rd_lat = 0; rd_dir = 0;
    #1;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    @(negedge clk);
    do_read(2, v); check("R1 dir", v, 8'hFF);
    do_read(1, v); check("R1 lat", v, 8'h00);
    do_read(0, v); check("R1 port", v, 8'h00);
    check("R1 oe", pad_oe, 8'h00);
  endtask

  task automatic t_latch_dir;
    logic [7:0] v;
    do_write(0, 8'h3C);
    do_read(1, v); check("R3 wr_lat", v, 8'h3C);
    check("R2 inputs stay off", pad_oe, 8'h00);
    do_write(1, 8'hA6);
    do_read(1, v); check("R3 wr_port", v, 8'hA6);
    do_write(2, 8'hF0);
    do_read(2, v); check("R4 dir", v, 8'hF0);
    check("R2 oe", pad_oe, 8'h0F);
    check("R2 out low nibble", pad_out & 8'h0F, 8'h06);
    pad_in = 8'h55;
    @(negedge clk); @(negedge clk);
    do_read(1, v); check("R3 latch not pin", v, 8'hA6);
  endtask

  task automatic t_sync;
    logic [7:0] v;
    @(negedge clk);
    pad_in = 8'hC3;
    @(negedge clk);
    do_read(0, v); check("R5 one edge", v, 8'h55);
    @(negedge clk);
    do_read(0, v); check("R5 two edges", v, 8'hC3);
    check("R5 periph_din", periph_din, 8'hC3);
  endtask

  task automatic t_read_prio;
    logic [7:0] v;
    @(negedge clk);
    rd_port = 1; rd_lat = 1; rd_dir = 1; #1 v = rdata;
    check("R6 port first", v, 8'hC3);
    rd_port = 0; #1 v = rdata;
    check("R6 latch second", v, 8'hA6);
    rd_lat = 0; #1 v = rdata;
    check("R6 dir last", v, 8'hF0);
    rd_dir = 0; #1 v = rdata;
    check("R6 idle zero", v, 8'h00);
  endtask

  task automatic t_ovr_out;
    logic [7:0] v;
    do_write(2, 8'hFF);
    do_write(0, 8'h00);
    @(negedge clk);
    periph_en = 8'hFF; periph_osel = 8'hFF; periph_dout = 8'hA5;
    #1;
    check("R7 forced out", pad_oe, 8'h7F);
    check("R8 periph data", pad_out, 8'hA5);
    @(negedge clk);
    do_read(2, v); check("R9 dir kept", v, 8'hFF);
  endtask

  task automatic t_ovr_in;
    logic [7:0] v;
    do_write(2, 8'h00);
    do_write(0, 8'h5A);
    @(negedge clk);
    periph_en = 8'hFF; periph_osel = 8'h00; periph_dout = 8'hFF;
    #1;
    check("R7 forced in", pad_oe, 8'h80);
    check("R8 latch when osel low", pad_out, 8'h5A);
    do_read(2, v); check("R9 dir under ovr", v, 8'h00);
    @(negedge clk);
    periph_en = 8'h00;
    #1;
    check("R9 release", pad_oe, 8'hFF);
  endtask

  task automatic t_pin7;
    do_write(2, 8'hFF);
    do_write(0, 8'h00);
    @(negedge clk);
    periph_en = 8'h80; periph_osel = 8'h80; periph_dout = 8'h80;
    #1;
    check("R10 pin7 stays input", pad_oe, 8'h00);
    do_write(2, 8'h7F);
    #1;
    check("R10 pin7 out via dir", pad_oe, 8'h80);
    check("R10 R8 pin7 data", pad_out, 8'h80);
    @(negedge clk);
    periph_en = 8'h00; periph_osel = 8'h00;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_latch_dir();
    t_sync();
    t_read_prio();
    t_ovr_out();
    t_ovr_in();
    t_pin7();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule